// File: doc/BRIEF.md
# Page Program Collector with In-Page Wrap

This block gathers the data bytes of a page-program command into a page-sized staging buffer before the array write. When a command is accepted, the block takes the page number from the upper address bits and the starting byte offset from the lower bits. It then clears its staging buffer and its byte-enable mask. Each received byte lands at the current offset, and the offset advances modulo the page size, so the write stays inside the same page. A later byte at an offset that was already written replaces the earlier one. The mask marks exactly the offsets written, so the array write can leave every other byte of the page untouched.

The command ends on the chip-select rising edge. It is committed only if that edge arrives exactly on a byte boundary and at least one byte was received. Otherwise the block raises an abort pulse and commits nothing. A command that arrives while the write-enable latch is clear is dropped without any effect. After a commit, a simple cycle counter stands in for the self-timed array write. While that counter runs, the block ignores new commands and holds its buffer and mask.

Top module: `ppb_page_buffer`

## Requirements
- R1: A command start (`cmd_start` high while idle, not busy, and `wr_latch` high) loads the page number from `cmd_addr[ADDR_W-1:log2(PAGE_BYTES)]` and the starting offset from `cmd_addr[log2(PAGE_BYTES)-1:0]`. It also clears every bit of `page_mask` and every byte of `page_data` to zero by the next cycle.
- R2: Each `rx_valid` cycle during a command writes `rx_byte` to byte lane `offset` of `page_data` (bits `offset*8+7 : offset*8`), sets `page_mask[offset]`, and advances the offset by one.
- R3: After the last offset (PAGE_BYTES-1) the offset returns to 0 of the same page, and `commit_page` does not change for the whole command.
- R4: When more than PAGE_BYTES bytes are sent, each later byte replaces the earlier byte at the same offset. The final mask is all ones.
- R5: A chip-select rising edge (`cs_rise`) during a command, with `rx_bitpos` equal to 0 and at least one byte received, produces a one-cycle `commit` pulse in the next cycle. `commit_page` then carries the page number.
- R6: A chip-select rising edge during a command with `rx_bitpos` not 0, or with no byte received, produces a one-cycle `abort` pulse in the next cycle. There is no `commit` and no `busy` in that case.
- R7: A command started while `wr_latch` is low is ignored. Its bytes change neither `page_mask` nor `page_data`, and its chip-select rising edge produces neither `commit` nor `abort`.
- R8: `busy` rises together with `commit` and stays high for exactly BUSY_CYCLES cycles.
- R9: While `busy` is high, command starts, bytes and chip-select edges are ignored. `page_data`, `page_mask` and `commit_page` hold their values.
- R10: After reset, `commit`, `abort` and `busy` are low and `page_mask` and `page_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Page-program command decoded (one-cycle strobe) |
| cmd_addr | input | ADDR_W (24) | Full byte address that came with the command |
| wr_latch | input | 1 | State of the write-enable latch |
| rx_valid | input | 1 | A complete data byte was received |
| rx_byte | input | 8 | Received data byte |
| rx_bitpos | input | 3 | Bits already received of the byte in progress (0 = on a byte boundary) |
| cs_rise | input | 1 | Chip select has just gone inactive |
| commit | output | 1 | One-cycle request to program the page |
| commit_page | output | ADDR_W - log2(PAGE_BYTES) (16) | Page number to program |
| page_data | output | PAGE_BYTES*8 (2048) | Staged page, byte lane n at bits n*8+7 : n*8 |
| page_mask | output | PAGE_BYTES (256) | Byte enables, bit n set when lane n was written |
| abort | output | 1 | One-cycle pulse: command ended off a byte boundary or without data |
| busy | output | 1 | Program cycle in progress |

## Verification
The assertions check these properties on every cycle:
- the mask is empty right after a command is taken;
- the page number stays frozen while bytes arrive;
- a written lane holds its byte on the next cycle;
- the offset wraps from the last lane to lane 0;
- commit and abort never coincide, and busy rises only with commit;
- the buffer and mask are frozen during busy.

Only the bench scenarios can show that the complete mask and buffer contents match the arithmetic expectation. The bench sweeps every start offset with short, exactly-full and overflowing byte counts. It also shows the exact busy length, and that commands with the latch clear or commands issued during busy leave the outputs untouched.

// File: rtl/ppb_pkg.sv
// Shared types for the page program collector.
// Assumes nothing beyond a single clock domain.
package ppb_pkg;
    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,   // no command open
        FILL_OPEN = 1'b1    // accepting bytes of a command
    } fill_state_t;
endpackage

// File: rtl/ppb_ptr.sv
// Offset pointer for the page buffer.
// Loads the starting offset, advances modulo PAGE_BYTES on each write and
// keeps a saturating count of bytes taken so the top can tell whether any
// byte arrived. Assumes PAGE_BYTES is a power of two and load and adv are
// never high together.
module ppb_ptr #(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_off,
    input  logic             adv,
    output logic [OFF_W-1:0] ptr,
    output logic             has_data
);
    logic [CNT_W-1:0] taken;

    // Pointer: load on command start, step with natural wrap on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_off;
        end else if (adv) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Byte count: cleared on start, saturates at one full page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken <= '0;
        end else if (load) begin
            taken <= '0;
        end else if (adv && (taken != CNT_W'(PAGE_BYTES))) begin
            taken <= taken + 1'b1;
        end
    end

    assign has_data = (taken != '0);

    // R4: the count never passes one page even when bytes overflow.
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        taken <= CNT_W'(PAGE_BYTES));

    // R3: the last offset is followed by offset zero, never a new page.
    a_r3_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && (ptr == '1)) |=> (ptr == '0));
endmodule

// File: rtl/ppb_store.sv
// Page staging store: PAGE_BYTES byte lanes with one enable bit each.
// A clear empties every lane and enable. A write fills one lane and sets
// its enable. Assumes clr and we are never high together.
module ppb_store #(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [OFF_W-1:0]        waddr,
    input  logic [7:0]              wdata,
    output logic [PAGE_BYTES*8-1:0] data_flat,
    output logic [PAGE_BYTES-1:0]   mask
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        // One lane: cleared on command start, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                data_flat[g*8 +: 8] <= 8'h00;
                mask[g]             <= 1'b0;
            end else if (we && (waddr == OFF_W'(g))) begin
                data_flat[g*8 +: 8] <= wdata;
                mask[g]             <= 1'b1;
            end
        end
    end

    // R2: a written lane shows its enable and its byte on the next cycle.
    a_r2_lane_written: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (mask[$past(waddr)] &&
                          (data_flat[int'($past(waddr))*8 +: 8] == $past(wdata))));
endmodule

// File: rtl/ppb_timer.sv
// Busy timer standing in for the self-timed array program.
// Loading starts a window of exactly BUSY_CYCLES cycles with busy high.
// Assumes load only arrives while idle.
module ppb_timer #(
    parameter int BUSY_CYCLES = 200000,
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    logic [CNT_W-1:0] remain;

    // Down-counter: loaded on commit, counts to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CNT_W'(BUSY_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    // R8: a program cycle is never started on top of a running one.
    a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

    // R8: busy follows a load in the next cycle.
    a_r8_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/ppb_page_buffer.sv
// Page program collector, top level.
// Takes a page-program command, stages its data bytes with in-page wrap,
// and on chip-select release either requests a commit (on a byte boundary
// with data) or reports an abort. Runs a busy window after each commit.
// Assumes the upstream shifter asserts rx_valid once per complete byte and
// reports the partial bit count on rx_bitpos.
module ppb_page_buffer
    import ppb_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PAGE_BYTES  = 256,
    parameter int BUSY_CYCLES = 200000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_start,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic                    wr_latch,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic [2:0]              rx_bitpos,
    input  logic                    cs_rise,
    output logic                    commit,
    output logic [PAGE_W-1:0]       commit_page,
    output logic [PAGE_BYTES*8-1:0] page_data,
    output logic [PAGE_BYTES-1:0]   page_mask,
    output logic                    abort,
    output logic                    busy
);
    fill_state_t      state;
    logic             take;
    logic             filling;
    logic             wr;
    logic             close;
    logic             good_end;
    logic             has_data;
    logic [OFF_W-1:0] ptr;

    assign filling  = (state == FILL_OPEN);
    assign take     = cmd_start && (state == FILL_IDLE) && !busy && wr_latch;
    assign wr       = filling && rx_valid;
    assign close    = filling && cs_rise;
    assign good_end = close && (rx_bitpos == 3'd0) && (has_data || rx_valid);

    // Command state: open on an accepted start, close on chip-select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FILL_IDLE;
        end else if (take) begin
            state <= FILL_OPEN;
        end else if (close) begin
            state <= FILL_IDLE;
        end
    end

    // Page number register: captured once per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_page <= '0;
        end else if (take) begin
            commit_page <= cmd_addr[ADDR_W-1:OFF_W];
        end
    end

    // End-of-command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit <= 1'b0;
            abort  <= 1'b0;
        end else begin
            commit <= good_end;
            abort  <= close && !good_end;
        end
    end

    ppb_ptr #(.PAGE_BYTES(PAGE_BYTES)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_off (cmd_addr[OFF_W-1:0]),
        .adv      (wr),
        .ptr      (ptr),
        .has_data (has_data)
    );

    ppb_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (take),
        .we        (wr),
        .waddr     (ptr),
        .wdata     (rx_byte),
        .data_flat (page_data),
        .mask      (page_mask)
    );

    ppb_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (good_end),
        .busy  (busy)
    );

    // R1: an accepted command leaves an empty mask behind.
    a_r1_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (page_mask == '0));

    // R3: the page number is frozen while bytes are collected.
    a_r3_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        filling |=> $stable(commit_page));

    // R5: a commit always comes with busy.
    a_r5_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    // R5: busy only rises through a commit.
    a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> commit);

    // R6: a command ends in commit or abort, never both.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && abort));

    // R9: staged contents are frozen during the program cycle.
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(page_mask) && $stable(page_data) && $stable(commit_page)));
endmodule

// File: tb/ppb_page_buffer_test.sv
// Bench for the page program collector on a 16-byte page.
module ppb_page_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PB  = 16;
    localparam int BC  = 5;
    localparam int AW  = 24;
    localparam int OW  = 4;
    localparam int PW  = AW - OW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cmd_start, wr_latch, rx_valid, cs_rise;
    logic [AW-1:0]   cmd_addr;
    logic [7:0]      rx_byte;
    logic [2:0]      rx_bitpos;
    logic            commit, abort, busy;
    logic [PW-1:0]   commit_page;
    logic [PB*8-1:0] page_data;
    logic [PB-1:0]   page_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]    exp_data [PB];
    logic [PB-1:0] exp_mask;
    logic [PW-1:0] exp_page;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppb_page_buffer #(.ADDR_W(AW), .PAGE_BYTES(PB), .BUSY_CYCLES(BC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .wr_latch(wr_latch), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_bitpos(rx_bitpos), .cs_rise(cs_rise), .commit(commit),
        .commit_page(commit_page), .page_data(page_data), .page_mask(page_mask),
        .abort(abort), .busy(busy)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(input int off, input int n, input int k);
        return 8'((off * 37 + k * 11 + n * 5) ^ 8'h5A);
    endfunction

    // Runs one command from a negedge; ends at the negedge after cs release.
    task automatic run_prog(input int off, input int n, input logic [PW-1:0] pg,
                            input logic wel, input logic [2:0] endbit,
                            input bit accepted);
        cmd_start = 1'b1;
        cmd_addr  = {pg, 4'(off)};
        wr_latch  = wel;
        @(negedge clk);
        cmd_start = 1'b0;
        if (accepted) begin
            exp_mask = '0;
            exp_page = pg;
            for (int i = 0; i < PB; i++) exp_data[i] = 8'h00;
        end
        for (int k = 0; k < n; k++) begin
            rx_valid = 1'b1;
            rx_byte  = byte_val(off, n, k);
            if (accepted) begin
                exp_data[(off + k) % PB] = rx_byte;
                exp_mask[(off + k) % PB] = 1'b1;
            end
            @(negedge clk);
            rx_valid = 1'b0;
        end
        rx_bitpos = endbit;
        cs_rise   = 1'b1;
        @(negedge clk);
        cs_rise   = 1'b0;
        rx_bitpos = 3'd0;
    endtask

    task automatic check_contents(input string req);
        check(req, "page_mask", 32'(page_mask), 32'(exp_mask));
        check(req, "commit_page", 32'(commit_page), 32'(exp_page));
        for (int i = 0; i < PB; i++)
            check(req, $sformatf("lane %0d", i), 32'(page_data[i*8 +: 8]), 32'(exp_data[i]));
    endtask

    // Called on the negedge where commit is visible; checks the busy window.
    task automatic check_busy_window();
        check("R8", "busy with commit", 32'(busy), 32'd1);
        for (int c = 1; c < BC; c++) begin
            @(negedge clk);
            check("R8", "busy held", 32'(busy), 32'd1);
            check("R5", "commit single pulse", 32'(commit), 32'd0);
        end
        @(negedge clk);
        check("R8", "busy ends", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int counts [4] = '{1, 7, 16, 21};
        rst_n = 1'b0; cmd_start = 1'b0; cmd_addr = '0; wr_latch = 1'b0;
        rx_valid = 1'b0; rx_byte = 8'h00; rx_bitpos = 3'd0; cs_rise = 1'b0;
        exp_mask = '0; exp_page = '0;
        for (int i = 0; i < PB; i++) exp_data[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state.
        check("R10", "commit", 32'(commit), 32'd0);
        check("R10", "abort", 32'(abort), 32'd0);
        check("R10", "busy", 32'(busy), 32'd0);
        check("R10", "mask", 32'(page_mask), 32'd0);
        check("R10", "data zero", 32'(page_data == '0), 32'd1);

        // R2/R3/R4/R5: sweep every start offset with several byte counts.
        for (int off = 0; off < PB; off++) begin
            for (int ci = 0; ci < 4; ci++) begin
                int n = counts[ci];
                string req;
                logic [PW-1:0] pg = PW'(off * 4 + ci + 1);
                req = (n > PB) ? "R4" : ((off + n > PB) ? "R3" : "R2");
                run_prog(off, n, pg, 1'b1, 3'd0, 1'b1);
                check("R5", "commit", 32'(commit), 32'd1);
                check("R6", "no abort on boundary", 32'(abort), 32'd0);
                check_contents(req);
                check_busy_window();
            end
        end

        // R1: a fresh command clears lanes left by the previous one.
        run_prog(14, 1, 20'h00ABC, 1'b1, 3'd0, 1'b1);
        check("R1", "commit", 32'(commit), 32'd1);
        check_contents("R1");
        check_busy_window();

        // R6: release in the middle of a byte aborts.
        run_prog(3, 4, 20'h00111, 1'b1, 3'd5, 1'b1);
        check("R6", "abort mid-byte", 32'(abort), 32'd1);
        check("R6", "no commit mid-byte", 32'(commit), 32'd0);
        check("R6", "no busy mid-byte", 32'(busy), 32'd0);
        @(negedge clk);
        check("R6", "abort single pulse", 32'(abort), 32'd0);

        // R6: release with no data aborts.
        run_prog(0, 0, 20'h00222, 1'b1, 3'd0, 1'b1);
        check("R6", "abort no data", 32'(abort), 32'd1);
        check("R6", "no commit no data", 32'(commit), 32'd0);
        @(negedge clk);

        // Known contents before the ignore tests.
        run_prog(6, 5, 20'h00333, 1'b1, 3'd0, 1'b1);
        check("R5", "commit", 32'(commit), 32'd1);
        check_busy_window();

        // R7: latch clear, command ignored.
        run_prog(9, 3, 20'h00444, 1'b0, 3'd0, 1'b0);
        check("R7", "no commit", 32'(commit), 32'd0);
        check("R7", "no abort", 32'(abort), 32'd0);
        check("R7", "no busy", 32'(busy), 32'd0);
        check_contents("R7");

        // R9: command during the busy window is ignored.
        run_prog(1, 2, 20'h00555, 1'b1, 3'd0, 1'b1);
        check("R5", "commit", 32'(commit), 32'd1);
        run_prog(10, 2, 20'h00666, 1'b1, 3'd0, 1'b0);
        check("R9", "busy still high", 32'(busy), 32'd1);
        check("R9", "no second commit", 32'(commit), 32'd0);
        check("R9", "no abort", 32'(abort), 32'd0);
        check_contents("R9");
        repeat (BC) @(negedge clk);
        check("R9", "busy cleared", 32'(busy), 32'd0);
        check("R9", "still no commit", 32'(commit), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule